// File: doc/BRIEF.md
# J/K Delimiter Code-Group Aligner

The block sits between a descrambler and a 4B/5B symbol decoder. It receives bits one at a time, each marked by a valid strobe, with no knowledge of where the 5-bit code groups begin. It watches the ten most recent valid bits for the start-of-stream delimiter pair /J/ then /K/. When that pattern completes, the block fixes the group boundary at the last bit of /K/ and emits one pulse that marks the start of a stream. From then on it delivers each run of five following valid bits as one code group, together with a one-cycle strobe.

Alignment lasts until the stream ends or the link is lost. Two idle groups in a row release it, and so does an end-of-stream /T/ followed by /R/. A drop of the descrambler's locked flag also releases it. Once released, the block searches again, so the next /J/K/ can set a new boundary at any bit offset. The block emits no groups while it is searching.

Top module: `jk_aligner`

## Requirements
- R1: Once reset is released, grp_o, grp_vld_o, aligned_o and sos_o are all 0.
- R2: Suppose lock_i is high and the block is not aligned. When a valid bit makes the ten latest valid bits, oldest first, equal to 1100010001, sos_o is high for exactly the one cycle after that clock edge, and aligned_o rises in that same cycle. A pattern that differs in any bit produces no pulse.
- R3: While aligned, every fifth valid bit counted from the match produces a one-cycle grp_vld_o pulse after its edge. grp_o then holds those five bits, with the first one received in bit 4 and the last in bit 0.
- R4: grp_vld_o stays low on every cycle in which the block was not aligned before the edge.
- R5: lock_i low at a clock edge clears aligned_o and resets the group count. It also blocks any match. This takes precedence over a valid bit sampled on the same edge, so that bit completes no group.
- R6: Two consecutive groups equal to 11111 clear aligned_o on the edge that delivers the second one, and that group is still presented with grp_vld_o. A single 11111 followed by any other group keeps the alignment.
- R7: A group 01101 followed directly by 00111 clears aligned_o in the same way. A group 01101 followed by any other group keeps the alignment.
- R8: While aligned, a /J/K/ bit pattern in the stream causes no sos_o and does not move the boundary. After a release, a new /J/K/ at a different bit offset sets a new boundary.
- R9: Cycles with bit_vld_i low shift no bit and advance no count. They produce neither grp_vld_o nor sos_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_vld_i | input | 1 | Marks bit_i as carrying a new bit this cycle |
| bit_i | input | 1 | Descrambled serial bit |
| lock_i | input | 1 | Descrambler lock indication |
| grp_o | output | 5 | Aligned code group, first received bit in bit 4 |
| grp_vld_o | output | 1 | One-cycle strobe when grp_o holds a new group |
| aligned_o | output | 1 | A group boundary is currently fixed |
| sos_o | output | 1 | One-cycle pulse when /J/K/ completes |

## Verification
On every cycle the assertions check several relations. The start pulse always coincides with the rise of alignment and follows a valid, locked 1 bit. It never lasts two cycles. Group strobes appear only after aligned, valid, locked bits, and a lost lock always removes the alignment on the next cycle. A fall of alignment while locked must be caused by a delivered idle group or /R/ group. Only the bench's scenarios can show the rest. These cover the exact position and contents of each group for different prefix offsets and with gaps in the valid strobe. They also cover the rejection of a near-miss pattern and the single-idle and /T/-then-other cases that must keep alignment. A further scenario checks that a bit sampled together with a lock drop is discarded, and that a fresh /J/K/ after release re-anchors the boundary.

// File: rtl/jk_align_pkg.sv
package jk_align_pkg;
  parameter int unsigned GRP_W   = 5;
  parameter int unsigned DELIM_W = 2 * GRP_W;
  parameter int unsigned CNT_W   = $clog2(GRP_W);

  parameter logic [DELIM_W-1:0] DELIM_JK = 10'b11000_10001;
  parameter logic [GRP_W-1:0]   GRP_IDLE = 5'b11111;
  parameter logic [GRP_W-1:0]   GRP_T    = 5'b01101;
  parameter logic [GRP_W-1:0]   GRP_R    = 5'b00111;
endpackage

// File: rtl/jk_bit_window.sv
module jk_bit_window #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] win_nxt_o
);
  // only W-1 bits are stored; the newest bit comes straight from the input
  logic [W-2:0] win_q;

  assign win_nxt_o = {win_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      win_q <= '0;
    else if (shift_i) win_q <= win_nxt_o[W-2:0];
  end
endmodule

// File: rtl/jk_delim_match.sv
module jk_delim_match #(
  parameter int unsigned     W   = 10,
  parameter logic [W-1:0]    PAT = '0
) (
  input  logic         en_i,
  input  logic [W-1:0] win_i,
  output logic         hit_o
);
  logic [W-1:0] eq;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign eq[i] = ~(win_i[i] ^ PAT[i]);
  end

  assign hit_o = en_i & (&eq);
endmodule

// File: rtl/jk_group_collect.sv
module jk_group_collect
  import jk_align_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [GRP_W-1:0] bits_i,
  output logic             done_o,
  output logic [GRP_W-1:0] grp_o,
  output logic             grp_vld_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GRP_W - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = step_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      grp_o     <= '0;
      grp_vld_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q     <= '0;
      grp_vld_o <= 1'b0;
    end else if (done_o) begin
      cnt_q     <= '0;
      grp_o     <= bits_i;
      grp_vld_o <= 1'b1;
    end else begin
      if (step_i) cnt_q <= cnt_q + 1'b1;
      grp_vld_o <= 1'b0;
    end
  end
endmodule

// File: rtl/jk_release_detect.sv
module jk_release_detect
  import jk_align_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             done_i,
  input  logic [GRP_W-1:0] grp_i,
  output logic             rel_o
);
  logic [GRP_W-1:0] prev_q;
  logic             prev_ok_q;

  always_comb begin
    rel_o = 1'b0;
    if (done_i && prev_ok_q) begin
      if (prev_q == GRP_IDLE && grp_i == GRP_IDLE) rel_o = 1'b1;
      if (prev_q == GRP_T    && grp_i == GRP_R)    rel_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q    <= '0;
      prev_ok_q <= 1'b0;
    end else if (clr_i) begin
      prev_ok_q <= 1'b0;
    end else if (done_i) begin
      prev_q    <= grp_i;
      prev_ok_q <= 1'b1;
    end
  end
endmodule

// File: rtl/jk_aligner.sv
module jk_aligner
  import jk_align_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_vld_i,
  input  logic             bit_i,
  input  logic             lock_i,
  output logic [GRP_W-1:0] grp_o,
  output logic             grp_vld_o,
  output logic             aligned_o,
  output logic             sos_o
);
  logic [DELIM_W-1:0] win_nxt;
  logic               hit, step, clr, done, rel;

  assign step = bit_vld_i & lock_i & aligned_o;
  assign clr  = ~lock_i | hit;

  jk_bit_window #(.W(DELIM_W)) i_window (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_i   (bit_vld_i),
    .bit_i     (bit_i),
    .win_nxt_o (win_nxt)
  );

  jk_delim_match #(.W(DELIM_W), .PAT(DELIM_JK)) i_match (
    .en_i  (bit_vld_i & lock_i & ~aligned_o),
    .win_i (win_nxt),
    .hit_o (hit)
  );

  jk_group_collect i_collect (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .step_i    (step),
    .bits_i    (win_nxt[GRP_W-1:0]),
    .done_o    (done),
    .grp_o     (grp_o),
    .grp_vld_o (grp_vld_o)
  );

  jk_release_detect i_release (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .done_i (done),
    .grp_i  (win_nxt[GRP_W-1:0]),
    .rel_o  (rel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aligned_o <= 1'b0;
      sos_o     <= 1'b0;
    end else begin
      sos_o <= hit;
      if (!lock_i)  aligned_o <= 1'b0;
      else if (hit) aligned_o <= 1'b1;
      else if (rel) aligned_o <= 1'b0;
    end
  end
endmodule

// File: rtl/jk_aligner_chk.sv
module jk_aligner_chk
  import jk_align_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_vld_i,
  input logic             bit_i,
  input logic             lock_i,
  input logic [GRP_W-1:0] grp_o,
  input logic             grp_vld_o,
  input logic             aligned_o,
  input logic             sos_o
);
  // R2
  sos_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sos_o |-> $rose(aligned_o) && $past(bit_vld_i) && $past(lock_i) && $past(bit_i));

  // R2
  sos_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sos_o |=> !sos_o);

  // R8
  align_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aligned_o) |-> sos_o);

  // R4
  grp_when_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_vld_o |-> $past(aligned_o) && $past(bit_vld_i) && $past(lock_i));

  // R5
  lock_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |=> !aligned_o);

  // R6 R7
  release_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(aligned_o) && $past(lock_i) |-> grp_vld_o && (grp_o == GRP_IDLE || grp_o == GRP_R));

  // R9
  no_bit_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i |=> !grp_vld_o && !sos_o);
endmodule

bind jk_aligner jk_aligner_chk i_chk (.*);

// File: tb/test_jk_aligner.sv
`timescale 1ns/1ps
module test_jk_aligner;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_vld_i = 1'b0;
  logic       bit_i = 1'b0;
  logic       lock_i = 1'b0;
  logic [4:0] grp_o;
  logic       grp_vld_o, aligned_o, sos_o;

  int         n_chk = 0, n_fail = 0;
  logic [4:0] glog [0:63];
  int         gn = 0, sos_n = 0;
  bit         done_flag = 0;

  always #10 clk_i = ~clk_i;

  jk_aligner i_jk_aligner (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic observe();
    if (grp_vld_o && gn < 64) begin glog[gn] = grp_o; gn++; end
    if (sos_o) sos_n++;
  endtask

  task automatic send_bit(input logic b);
    bit_i = b; bit_vld_i = 1'b1;
    @(posedge clk_i); #1;
    bit_vld_i = 1'b0;
    observe();
  endtask

  task automatic gap();
    bit_vld_i = 1'b0;
    @(posedge clk_i); #1;
    observe();
  endtask

  task automatic send_grp(input logic [4:0] g);
    for (int i = 4; i >= 0; i--) send_bit(g[i]);
  endtask

  task automatic send_jk();
    for (int i = 9; i >= 0; i--) send_bit(10'b1100010001 >> i);
  endtask

  task automatic clear_log();
    gn = 0; sos_n = 0;
  endtask

  task automatic unalign();
    lock_i = 1'b0; gap(); lock_i = 1'b1;
    for (int i = 0; i < 12; i++) send_bit(1'b1);
    clear_log();
  endtask

  task automatic t_reset();
    chk(grp_o == 0 && !grp_vld_o && !aligned_o && !sos_o, "R1 reset outputs",
        {grp_o, grp_vld_o, aligned_o, sos_o}, 0);
  endtask

  task automatic t_basic();
    unalign();
    for (int i = 9; i >= 1; i--) send_bit(10'b1100010001 >> i);
    chk(!sos_o && !aligned_o, "R2 no early match", {sos_o, aligned_o}, 0);
    send_bit(1'b1);
    chk(sos_o && aligned_o, "R2 match pulse", {sos_o, aligned_o}, 3);
    gap();
    chk(!sos_o && aligned_o, "R2 single-cycle pulse", {sos_o, aligned_o}, 1);
    clear_log();
    for (int i = 4; i >= 1; i--) send_bit(5'h0E >> i);
    chk(gn == 0, "R3 no strobe mid-group", gn, 0);
    send_bit(1'b0);
    chk(grp_vld_o && grp_o == 5'h0E, "R3 first group", grp_o, 5'h0E);
    send_grp(5'h15); send_grp(5'h03);
    chk(gn == 3 && glog[1] == 5'h15 && glog[2] == 5'h03, "R3 group sequence", gn, 3);
    send_grp(5'h1F);
    chk(aligned_o, "R6 single idle holds", aligned_o, 1);
    send_grp(5'h1F);
    chk(!aligned_o && grp_vld_o && grp_o == 5'h1F, "R6 two idles release", aligned_o, 0);
  endtask

  task automatic t_offset();
    unalign();
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    send_jk();
    chk(sos_n == 1 && aligned_o, "R2 match after offset prefix", sos_n, 1);
    clear_log();
    for (int i = 4; i >= 0; i--) begin send_bit(5'h19 >> i); gap(); gap(); end
    chk(gn == 1 && glog[0] == 5'h19, "R9 group with valid gaps", glog[0], 5'h19);
    chk(!grp_vld_o, "R9 no strobe on idle cycle", grp_vld_o, 0);
    send_grp(5'h0D);
    chk(aligned_o, "R7 T alone holds", aligned_o, 1);
    send_grp(5'h07);
    chk(!aligned_o && grp_o == 5'h07, "R7 T then R release", aligned_o, 0);
  endtask

  task automatic t_lock();
    unalign();
    for (int i = 9; i >= 0; i--) send_bit(10'b1100010011 >> i);
    chk(sos_n == 0 && !aligned_o, "R2 near miss rejected", sos_n, 0);
    lock_i = 1'b0;
    send_jk();
    chk(sos_n == 0 && !aligned_o, "R5 match blocked without lock", sos_n, 0);
    lock_i = 1'b1;
    for (int i = 0; i < 10; i++) send_bit(i[0]);
    chk(gn == 0, "R4 no groups while searching", gn, 0);
    unalign();
    send_jk();
    lock_i = 1'b0; gap();
    chk(!aligned_o, "R5 lock drop clears", aligned_o, 1'b0);
    lock_i = 1'b1; clear_log();
    for (int i = 0; i < 15; i++) send_bit(i[0]);
    chk(gn == 0, "R4 no groups after lock loss", gn, 0);
    unalign();
    send_jk(); clear_log();
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    lock_i = 1'b0; send_bit(1'b0);
    chk(gn == 0 && !aligned_o, "R5 lock drop beats valid bit", gn, 0);
    lock_i = 1'b1;
  endtask

  task automatic t_realign();
    unalign();
    send_jk(); clear_log();
    send_grp(5'h1F); send_grp(5'h15); send_grp(5'h1F);
    chk(aligned_o, "R6 idle-data-idle holds", aligned_o, 1);
    send_grp(5'h0D); send_grp(5'h15);
    chk(aligned_o, "R7 T then other holds", aligned_o, 1);
    send_grp(5'h18); send_grp(5'h11);
    chk(sos_n == 0 && aligned_o && glog[6] == 5'h11, "R8 no match while aligned", sos_n, 0);
    send_grp(5'h1F); send_grp(5'h1F);
    chk(!aligned_o, "R6 release before realign", aligned_o, 0);
    send_bit(1'b0); send_bit(1'b0);
    send_jk();
    chk(sos_n == 1 && aligned_o, "R8 new match after release", sos_n, 1);
    clear_log();
    send_grp(5'h0A);
    chk(gn == 1 && glog[0] == 5'h0A, "R8 new boundary group", glog[0], 5'h0A);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    t_reset();
    t_basic();
    t_offset();
    t_lock();
    t_realign();
    summary();
  end
endmodule